// File: doc/BRIEF.md
# Transactional Line Coherence State Controller

This block holds the coherence state of one line in a snooping private cache. It uses the four usual states (invalid, shared, exclusive, modified) and adds two transactional states. The speculative state (`LS_SPEC`) keeps a transactionally stored value private to this cache. The isolated state (`LS_ISO`) keeps a reader on the value that existed before remote speculative writes. Several speculative writers and readers may hold the same line at once. Commit and abort are settled locally, with no bus traffic.

Each cycle the block takes one event code. An event is a local load or store (normal or transactional), a snooped request, a commit, an abort or an eviction notice. The outputs are combinational in the current state and the event: the bus request type, a data-response enable, a threatened response and an overflow alert. The state register takes the next state on the rising clock edge. A fill uses two sampled response inputs: `shared_i` (another cache holds the line) and `threat_i` (a remote speculative writer answered the read).

Top module: `txn_line_ctrl`

## Requirements
- R1: After reset the state output is invalid. State codes: invalid=0, shared=1, exclusive=2, modified=3, speculative=4, isolated=5.
- R2: Event codes are NOP=0, LD=1, ST=2, TLD=3, TST=4, SN_RD=5, SN_RDX=6, SN_TRDX=7, COMMIT=8, ABORT=9, EVICT=10. Bus request codes are NONE=0, RD=1, RDX=2, TRDX=3, WB=4.
- R3: Normal events follow MESI.
  - LD from invalid requests RD and fills shared (if `shared_i`) or exclusive.
  - ST requests RDX from invalid or shared, and is silent from exclusive.
  - SN_RD moves exclusive or modified to shared, with a data response.
  - SN_RDX invalidates the line.
  - EVICT of a modified line requests WB.
- R4: TST from invalid, shared or isolated requests TRDX and enters speculative. From exclusive it enters speculative silently.
- R5: A speculative line ignores SN_TRDX. The state is kept and all outputs stay low.
- R6: A speculative line that snoops SN_RD asserts the threatened response, keeps its data response low and stays speculative.
- R7: TLD from invalid with `threat_i` high requests RD and enters isolated.
- R8: An isolated line drops to invalid on SN_RDX, SN_TRDX or EVICT, with no alert.
- R9: Commit moves speculative to modified and isolated to invalid. Abort moves both to invalid.
- R10: Commit and abort never issue a bus request.
- R11: TST on a modified line requests WB and enters speculative.
- R12: TLD with `threat_i` low fills shared or exclusive, exactly as LD does.
- R13: Evicting a speculative line raises the alert and goes invalid. A snooped SN_RDX on a speculative line does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 4 | Event code for this cycle |
| shared_i | input | 1 | Fill response: another cache holds the line |
| threat_i | input | 1 | Fill response: threatened by a speculative writer |
| state_o | output | 3 | Current line state |
| bus_req_o | output | 3 | Bus request type for this event |
| data_resp_o | output | 1 | Supply data on the snooped request |
| threat_o | output | 1 | Threatened response on the snooped read |
| alert_o | output | 1 | Alert to the active thread: speculative line lost |

## Verification
The assertions assume `ev_i` carries only the eleven defined codes. They also assume the response inputs matter only in the cycle of a fill. The bench drives only defined codes. It changes inputs only on the falling edge, so every event holds stable over one rising edge. Stimulus reaches each state through legal event chains rather than forcing it, so every check sees a state the controller itself produced.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
    localparam int ST_W  = 3;
    localparam int EV_W  = 4;
    localparam int BUS_W = 3;

    typedef enum logic [ST_W-1:0] {
        LS_INV  = 3'd0,
        LS_SHR  = 3'd1,
        LS_EXC  = 3'd2,
        LS_MOD  = 3'd3,
        LS_SPEC = 3'd4,
        LS_ISO  = 3'd5
    } line_st_t;

    typedef enum logic [EV_W-1:0] {
        EV_NOP     = 4'd0,
        EV_LD      = 4'd1,
        EV_ST      = 4'd2,
        EV_TLD     = 4'd3,
        EV_TST     = 4'd4,
        EV_SN_RD   = 4'd5,
        EV_SN_RDX  = 4'd6,
        EV_SN_TRDX = 4'd7,
        EV_COMMIT  = 4'd8,
        EV_ABORT   = 4'd9,
        EV_EVICT   = 4'd10
    } ev_t;

    typedef enum logic [BUS_W-1:0] {
        BR_NONE = 3'd0,
        BR_RD   = 3'd1,
        BR_RDX  = 3'd2,
        BR_TRDX = 3'd3,
        BR_WB   = 3'd4
    } bus_t;
endpackage

// File: rtl/ttc_next.sv
module ttc_next
    import ttc_pkg::*;
(
    input  line_st_t cur_i,
    input  ev_t      ev_i,
    input  logic     shared_i,
    input  logic     threat_i,
    output line_st_t nxt_o
);
    line_st_t fill_st;

    always_comb begin
        fill_st = shared_i ? LS_SHR : LS_EXC;
        nxt_o   = cur_i;
        unique case (cur_i)
            LS_INV: begin
                case (ev_i)
                    EV_LD:   nxt_o = fill_st;
                    EV_TLD:  nxt_o = threat_i ? LS_ISO : fill_st;
                    EV_ST:   nxt_o = LS_MOD;
                    EV_TST:  nxt_o = LS_SPEC;
                    default: nxt_o = LS_INV;
                endcase
            end
            LS_SHR: begin
                case (ev_i)
                    EV_ST:                          nxt_o = LS_MOD;
                    EV_TST:                         nxt_o = LS_SPEC;
                    EV_SN_RDX, EV_SN_TRDX, EV_EVICT: nxt_o = LS_INV;
                    default:                        nxt_o = LS_SHR;
                endcase
            end
            LS_EXC: begin
                case (ev_i)
                    EV_ST:                          nxt_o = LS_MOD;
                    EV_TST:                         nxt_o = LS_SPEC;
                    EV_SN_RD:                       nxt_o = LS_SHR;
                    EV_SN_RDX, EV_SN_TRDX, EV_EVICT: nxt_o = LS_INV;
                    default:                        nxt_o = LS_EXC;
                endcase
            end
            LS_MOD: begin
                case (ev_i)
                    EV_TST:                         nxt_o = LS_SPEC;
                    EV_SN_RD:                       nxt_o = LS_SHR;
                    EV_SN_RDX, EV_SN_TRDX, EV_EVICT: nxt_o = LS_INV;
                    default:                        nxt_o = LS_MOD;
                endcase
            end
            LS_SPEC: begin
                case (ev_i)
                    EV_COMMIT:                     nxt_o = LS_MOD;
                    EV_ABORT, EV_SN_RDX, EV_EVICT: nxt_o = LS_INV;
                    default:                       nxt_o = LS_SPEC;
                endcase
            end
            LS_ISO: begin
                case (ev_i)
                    EV_ST:  nxt_o = LS_MOD;
                    EV_TST: nxt_o = LS_SPEC;
                    EV_COMMIT, EV_ABORT, EV_SN_RDX, EV_SN_TRDX, EV_EVICT:
                            nxt_o = LS_INV;
                    default: nxt_o = LS_ISO;
                endcase
            end
            default: nxt_o = LS_INV;
        endcase
    end
endmodule

// File: rtl/ttc_out.sv
module ttc_out
    import ttc_pkg::*;
(
    input  line_st_t cur_i,
    input  ev_t      ev_i,
    output bus_t     bus_o,
    output logic     dresp_o,
    output logic     threat_o,
    output logic     alert_o
);
    always_comb begin
        bus_o    = BR_NONE;
        dresp_o  = 1'b0;
        threat_o = 1'b0;
        alert_o  = 1'b0;
        unique case (cur_i)
            LS_INV: begin
                case (ev_i)
                    EV_LD, EV_TLD: bus_o = BR_RD;
                    EV_ST:         bus_o = BR_RDX;
                    EV_TST:        bus_o = BR_TRDX;
                    default:       bus_o = BR_NONE;
                endcase
            end
            LS_SHR, LS_ISO: begin
                case (ev_i)
                    EV_ST:   bus_o = BR_RDX;
                    EV_TST:  bus_o = BR_TRDX;
                    default: bus_o = BR_NONE;
                endcase
            end
            LS_EXC: begin
                dresp_o = (ev_i == EV_SN_RD);
            end
            LS_MOD: begin
                case (ev_i)
                    EV_TST, EV_EVICT:                 bus_o = BR_WB;
                    EV_SN_RD, EV_SN_RDX, EV_SN_TRDX:  dresp_o = 1'b1;
                    default:                          bus_o = BR_NONE;
                endcase
            end
            LS_SPEC: begin
                case (ev_i)
                    EV_SN_RD:            threat_o = 1'b1;
                    EV_SN_RDX, EV_EVICT: alert_o  = 1'b1;
                    default:             alert_o  = 1'b0;
                endcase
            end
            default: bus_o = BR_NONE;
        endcase
    end
endmodule

// File: rtl/txn_line_ctrl.sv
module txn_line_ctrl
    import ttc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_W-1:0]   ev_i,
    input  logic              shared_i,
    input  logic              threat_i,
    output logic [ST_W-1:0]   state_o,
    output logic [BUS_W-1:0]  bus_req_o,
    output logic              data_resp_o,
    output logic              threat_o,
    output logic              alert_o
);
    line_st_t state_q, state_d;
    ev_t      ev;
    bus_t     bus;

    assign ev = ev_t'(ev_i);

    ttc_next u_next (
        .cur_i    (state_q),
        .ev_i     (ev),
        .shared_i (shared_i),
        .threat_i (threat_i),
        .nxt_o    (state_d)
    );

    ttc_out u_out (
        .cur_i    (state_q),
        .ev_i     (ev),
        .bus_o    (bus),
        .dresp_o  (data_resp_o),
        .threat_o (threat_o),
        .alert_o  (alert_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_INV;
        else        state_q <= state_d;
    end

    assign state_o   = state_q;
    assign bus_req_o = bus;

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q <= LS_ISO); // R1
    AST_SPEC_TRDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SPEC && ev == EV_SN_TRDX) |=> state_q == LS_SPEC); // R5
    AST_THREAT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        threat_o |-> !data_resp_o && state_q == LS_SPEC); // R6
    AST_ISO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_ISO && ev == EV_COMMIT) |=> state_q == LS_INV); // R9
    AST_SPEC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LS_SPEC && ev == EV_COMMIT) |=> state_q == LS_MOD); // R9
    AST_LOCAL_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_COMMIT || ev == EV_ABORT) |-> bus_req_o == BR_NONE); // R10
    AST_ALERT_SPEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |-> state_q == LS_SPEC); // R13
    AST_ALERT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        alert_o |=> state_q == LS_INV); // R13
endmodule

// File: tb/txn_line_ctrl_tb.sv
module txn_line_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ev_i = 4'd0;
    logic       shared_i = 1'b0;
    logic       threat_i = 1'b0;
    logic [2:0] state_o, bus_req_o;
    logic       data_resp_o, threat_o, alert_o;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [2:0] bus;
        logic       dr;
        logic       thr;
        logic       al;
        logic [2:0] nst;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    txn_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .shared_i(shared_i),
        .threat_i(threat_i), .state_o(state_o), .bus_req_o(bus_req_o),
        .data_resp_o(data_resp_o), .threat_o(threat_o), .alert_o(alert_o)
    );

    task automatic step(input logic [3:0] ev, input logic sh, input logic th,
                        input logic [2:0] bus, input logic dr, input logic thr,
                        input logic al, input logic [2:0] nst, input string tag);
        exp_t e;
        @(negedge clk);
        ev_i = ev; shared_i = sh; threat_i = th;
        #1;
        e.bus = bus; e.dr = dr; e.thr = thr; e.al = al; e.nst = nst; e.tag = tag;
        sb_q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            exp_t e;
            wait (sb_q.size() > 0);
            e = sb_q[0];
            checks++;
            if ({bus_req_o, data_resp_o, threat_o, alert_o} !== {e.bus, e.dr, e.thr, e.al}) begin
                fails++;
                $display("FAIL %s outputs bus/dr/thr/al act=%0d/%0b/%0b/%0b exp=%0d/%0b/%0b/%0b",
                         e.tag, bus_req_o, data_resp_o, threat_o, alert_o,
                         e.bus, e.dr, e.thr, e.al);
            end
            @(posedge clk);
            #1;
            checks++;
            if (state_o !== e.nst) begin
                fails++;
                $display("FAIL %s state act=%0d exp=%0d", e.tag, state_o, e.nst);
            end
            void'(sb_q.pop_front());
        end
    end

    initial begin : watchdog
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // state 0 I,1 S,2 E,3 M,4 SPEC,5 ISO; bus 0 NONE,1 RD,2 RDX,3 TRDX,4 WB
    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (state_o !== 3'd0) begin
            fails++;
            $display("FAIL R1 reset state act=%0d exp=0", state_o);
        end
        @(negedge clk);
        rst_n = 1'b1;
        step(4'd1, 0, 0, 3'd1, 0, 0, 0, 3'd2, "R3 LD fill exclusive");
        step(4'd2, 0, 0, 3'd0, 0, 0, 0, 3'd3, "R3 ST silent from E");
        step(4'd5, 0, 0, 3'd0, 1, 0, 0, 3'd1, "R3 SN_RD on M");
        step(4'd6, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R3 SN_RDX on S");
        step(4'd1, 1, 0, 3'd1, 0, 0, 0, 3'd1, "R3 LD fill shared");
        step(4'd4, 0, 0, 3'd3, 0, 0, 0, 3'd4, "R4 TST from S");
        step(4'd7, 0, 0, 3'd0, 0, 0, 0, 3'd4, "R5 SPEC ignores SN_TRDX");
        step(4'd5, 0, 0, 3'd0, 0, 1, 0, 3'd4, "R6 SPEC threatened read");
        step(4'd8, 0, 0, 3'd0, 0, 0, 0, 3'd3, "R9 R10 commit SPEC");
        step(4'd4, 0, 0, 3'd4, 0, 0, 0, 3'd4, "R11 TST on M writes back");
        step(4'd9, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R9 R10 abort SPEC");
        step(4'd3, 1, 1, 3'd1, 0, 0, 0, 3'd5, "R7 TLD threatened");
        step(4'd7, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R8 ISO drop on SN_TRDX");
        step(4'd3, 1, 0, 3'd1, 0, 0, 0, 3'd1, "R12 TLD shared fill");
        step(4'd6, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R3 invalidate");
        step(4'd3, 0, 0, 3'd1, 0, 0, 0, 3'd2, "R12 TLD exclusive fill");
        step(4'd4, 0, 0, 3'd0, 0, 0, 0, 3'd4, "R4 TST silent from E");
        step(4'd10, 0, 0, 3'd0, 0, 0, 1, 3'd0, "R13 evict SPEC alert");
        step(4'd3, 0, 1, 3'd1, 0, 0, 0, 3'd5, "R7 TLD threatened again");
        step(4'd8, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R9 commit ISO");
        step(4'd3, 0, 1, 3'd1, 0, 0, 0, 3'd5, "R7 TLD to ISO");
        step(4'd10, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R8 ISO evict no alert");
        step(4'd4, 0, 0, 3'd3, 0, 0, 0, 3'd4, "R4 TST from I");
        step(4'd6, 0, 0, 3'd0, 0, 0, 1, 3'd0, "R13 SN_RDX on SPEC");
        step(4'd2, 0, 0, 3'd2, 0, 0, 0, 3'd3, "R3 ST from I");
        step(4'd8, 0, 0, 3'd0, 0, 0, 0, 3'd3, "R9 commit leaves M");
        step(4'd10, 0, 0, 3'd4, 0, 0, 0, 3'd0, "R3 evict M writes back");
        step(4'd0, 0, 0, 3'd0, 0, 0, 0, 3'd0, "R2 NOP");
        repeat (3) @(posedge clk);
        wait (sb_q.size() == 0);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule